// File: doc/BRIEF.md
# Ping-Pong Transmit Buffer Sequencer

This block holds the control state of a transmit buffer split into two halves, called ping (half 0) and pong (half 1), and decides when each half goes to a frame transmitter. A host writes words into a 4 KiB offset map. Each half has two leading data words, a frame-length word and a control word. The data array itself lies outside the block, so only those four words per half are kept here, as registers.

Setting the busy flag in a half's control word queues a job for that half. The job is either a frame send or a load of the 48-bit station address. The sequencer starts a frame by pulsing `tx_start` with the half index and the length. It then waits for `tx_done`, clears the busy flag and moves on to the other half if that half is queued. An address load completes in one cycle. Each completed job can raise a single-cycle interrupt, gated by a global enable pin and an enable bit held in the ping control word.

Top module: `pingpong_tx_seq`

## Requirements
- R1: After reset the station address is 0x00005E00FACE, every control word and length word reads 0, and `tx_start` and `tx_irq` are 0.
- R2: Suppose a control word is written with bit 31 = 1 and bit 30 = 0 while its half is idle (ping control at offset 0x7FC, pong control at 0xFFC). In the cycle after the write is registered, `tx_start` pulses for exactly one cycle. During that pulse, `tx_half` is 0 for ping or 1 for pong, and `tx_len` equals the low 16 bits of that half's length word (ping at 0x7F4, pong at 0xFF4).
- R3: Bit 31 of the control word reads 1 from the write until the cycle in which `tx_done` is sampled. It reads 0 from the next cycle on.
- R4: Suppose a control word is written with bits 31 and 30 both 1. Then no frame starts. One cycle after the write, the station address becomes {word at half offset 0x000, bits 15:0 of word at half offset 0x004}, and bits 31 and 30 of that control word read 0.
- R5: When a job on one half finishes and the other half's busy flag is set, the other half is started next. When neither flag is set, nothing starts.
- R6: `tx_irq` pulses for one cycle in the cycle after a busy flag is cleared, for both frame and address jobs. It pulses only if `gie` = 1 and bit 3 of the ping control word = 1.
- R7: A write to a control word whose busy flag is 1 is ignored. The word reads back unchanged.
- R8: While one half is being transmitted, the host can write the length and control words of the other half, and the next frame uses the newly written values.
- R9: A `tx_done` pulse while no frame is in flight changes no flag and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Byte offset of the host write (word aligned) |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 12 | Byte offset of the host read |
| host_rdata | output | 32 | Read data for `host_raddr` (combinational) |
| gie | input | 1 | Global interrupt enable |
| tx_start | output | 1 | One-cycle start pulse to the frame transmitter |
| tx_half | output | 1 | Half being transmitted (0 ping, 1 pong) |
| tx_len | output | LEN_W | Frame length for the started half |
| tx_done | input | 1 | One-cycle completion pulse from the transmitter |
| station_addr | output | 48 | Current station address |
| tx_irq | output | 1 | One-cycle transmit-complete interrupt |

## Verification
The checker assumes that `tx_done` is a single-cycle pulse and that the host uses word-aligned offsets. It does not assume that `tx_done` comes only after a start. A stray `tx_done` must simply be absorbed.

The bench's transmitter model answers every start with one done pulse after a random delay. It sends one extra done pulse while the block is idle, on purpose. Host writes go one per cycle, so queued jobs arise only by writing the other half while a frame is in flight, which is the situation the hand-over rule covers.

// File: rtl/pptx_pkg.sv
package pptx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned STA_W  = 48;

  // offsets inside one half (bit OFS_W-1 picks the half)
  localparam logic [OFS_W-2:0] OFS_ADDR_HI = 11'h000;
  localparam logic [OFS_W-2:0] OFS_ADDR_LO = 11'h004;
  localparam logic [OFS_W-2:0] OFS_LEN     = 11'h7F4;
  localparam logic [OFS_W-2:0] OFS_CTRL    = 11'h7FC;

  localparam int BUSY_BIT = 31;
  localparam int PROG_BIT = 30;
  localparam int IEN_BIT  = 3;

  localparam logic [STA_W-1:0] STATION_RESET = 48'h0000_5E00_FACE;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_ADDR_HI, FLD_ADDR_LO, FLD_LEN, FLD_CTRL
  } field_e;

  typedef struct packed {
    logic   half;
    field_e field;
  } target_t;

  typedef enum logic {SQ_IDLE, SQ_SEND} seq_state_e;

  function automatic target_t decode_offset(input logic [OFS_W-1:0] ofs);
    target_t t;
    t.half = ofs[OFS_W-1];
    case (ofs[OFS_W-2:0])
      OFS_ADDR_HI: t.field = FLD_ADDR_HI;
      OFS_ADDR_LO: t.field = FLD_ADDR_LO;
      OFS_LEN:     t.field = FLD_LEN;
      OFS_CTRL:    t.field = FLD_CTRL;
      default:     t.field = FLD_NONE;
    endcase
    return t;
  endfunction

  // keep only the defined control bits; program flag needs busy too
  function automatic logic [WORD_W-1:0] ctrl_store(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = '0;
    r[BUSY_BIT] = w[BUSY_BIT];
    r[PROG_BIT] = w[PROG_BIT] & w[BUSY_BIT];
    r[IEN_BIT]  = w[IEN_BIT];
    return r;
  endfunction

  function automatic logic [STA_W-1:0] station_from_words(
      input logic [WORD_W-1:0] hi, input logic [WORD_W-1:0] lo);
    return {hi, lo[15:0]};
  endfunction
endpackage

// File: rtl/pptx_half_regs.sv
module pptx_half_regs
  import pptx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  field_e            wr_field,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clr,
  output logic [WORD_W-1:0] addr_hi,
  output logic [WORD_W-1:0] addr_lo,
  output logic [LEN_W-1:0]  len,
  output logic [WORD_W-1:0] ctrl,
  output logic              busy,
  output logic              prog,
  output logic              ctrl_wr_busy
);
  assign busy         = ctrl[BUSY_BIT];
  assign prog         = ctrl[PROG_BIT];
  assign ctrl_wr_busy = wr_en && (wr_field == FLD_CTRL) && ctrl[BUSY_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_hi <= '0;
      addr_lo <= '0;
      len     <= '0;
      ctrl    <= '0;
    end else begin
      if (wr_en) begin
        case (wr_field)
          FLD_ADDR_HI: addr_hi <= wdata;
          FLD_ADDR_LO: addr_lo <= wdata;
          FLD_LEN:     len     <= wdata[LEN_W-1:0];
          FLD_CTRL:    if (!ctrl[BUSY_BIT]) ctrl <= ctrl_store(wdata);
          default:     ;
        endcase
      end
      if (clr) begin
        ctrl[BUSY_BIT] <= 1'b0;
        ctrl[PROG_BIT] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pptx_arbiter.sv
module pptx_arbiter (
  input  logic [1:0] ready,
  input  logic       pref,
  output logic       gnt_valid,
  output logic       gnt_half
);
  assign gnt_valid = |ready;
  assign gnt_half  = ready[pref] ? pref : ~pref;
endmodule

// File: rtl/pptx_ctrl.sv
module pptx_ctrl
  import pptx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gnt_valid,
  input  logic                   gnt_half,
  input  logic [1:0]             prog,
  input  logic [1:0][LEN_W-1:0]  len,
  input  logic [1:0][WORD_W-1:0] addr_hi,
  input  logic [1:0][WORD_W-1:0] addr_lo,
  input  logic                   tx_done,
  input  logic                   gie,
  input  logic                   ien,
  output logic                   tx_start,
  output logic                   tx_half,
  output logic [LEN_W-1:0]       tx_len,
  output logic [1:0]             clr,
  output logic                   irq,
  output logic [STA_W-1:0]       station,
  output logic                   pref,
  output logic                   sending,
  output logic                   prog_load
);
  seq_state_e state;
  logic       launch;
  logic       frame_go;
  logic       done_acc;

  assign sending   = (state == SQ_SEND);
  assign launch    = (state == SQ_IDLE) && gnt_valid;
  assign prog_load = launch && prog[gnt_half];
  assign frame_go  = launch && !prog[gnt_half];
  assign done_acc  = sending && tx_done;

  for (genvar h = 0; h < 2; h++) begin : g_clr
    assign clr[h] = (prog_load && (gnt_half == 1'(h))) ||
                    (done_acc  && (tx_half  == 1'(h)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      tx_start <= 1'b0;
      tx_half  <= 1'b0;
      tx_len   <= '0;
      irq      <= 1'b0;
      station  <= STATION_RESET;
      pref     <= 1'b0;
    end else begin
      tx_start <= frame_go;
      irq      <= (|clr) && gie && ien;
      if (launch) pref <= ~gnt_half;
      if (frame_go) begin
        state   <= SQ_SEND;
        tx_half <= gnt_half;
        tx_len  <= len[gnt_half];
      end else if (done_acc) begin
        state <= SQ_IDLE;
      end
      if (prog_load)
        station <= station_from_words(addr_hi[gnt_half], addr_lo[gnt_half]);
    end
  end
endmodule

// File: rtl/pingpong_tx_seq.sv
module pingpong_tx_seq
  import pptx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [11:0]       host_addr,
  input  logic [31:0]       host_wdata,
  input  logic [11:0]       host_raddr,
  output logic [31:0]       host_rdata,
  input  logic              gie,
  output logic              tx_start,
  output logic              tx_half,
  output logic [LEN_W-1:0]  tx_len,
  input  logic              tx_done,
  output logic [47:0]       station_addr,
  output logic              tx_irq
);
  target_t                wr_t;
  target_t                rd_t;
  logic [1:0][WORD_W-1:0] hi_q, lo_q, ctrl_q;
  logic [1:0][LEN_W-1:0]  len_q;
  logic [1:0]             busy_v, prog_v, clr_v, ctrl_wr_busy_v;
  logic                   gnt_valid, gnt_half, pref;
  logic                   sending, prog_load, irq_en;

  assign wr_t   = decode_offset(host_addr);
  assign rd_t   = decode_offset(host_raddr);
  assign irq_en = ctrl_q[0][IEN_BIT];

  for (genvar h = 0; h < 2; h++) begin : g_half
    pptx_half_regs #(.LEN_W(LEN_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (host_we && (wr_t.half == 1'(h))),
      .wr_field     (wr_t.field),
      .wdata        (host_wdata),
      .clr          (clr_v[h]),
      .addr_hi      (hi_q[h]),
      .addr_lo      (lo_q[h]),
      .len          (len_q[h]),
      .ctrl         (ctrl_q[h]),
      .busy         (busy_v[h]),
      .prog         (prog_v[h]),
      .ctrl_wr_busy (ctrl_wr_busy_v[h])
    );
  end

  pptx_arbiter u_arb (
    .ready     (busy_v),
    .pref      (pref),
    .gnt_valid (gnt_valid),
    .gnt_half  (gnt_half)
  );

  pptx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_valid (gnt_valid),
    .gnt_half  (gnt_half),
    .prog      (prog_v),
    .len       (len_q),
    .addr_hi   (hi_q),
    .addr_lo   (lo_q),
    .tx_done   (tx_done),
    .gie       (gie),
    .ien       (irq_en),
    .tx_start  (tx_start),
    .tx_half   (tx_half),
    .tx_len    (tx_len),
    .clr       (clr_v),
    .irq       (tx_irq),
    .station   (station_addr),
    .pref      (pref),
    .sending   (sending),
    .prog_load (prog_load)
  );

  always_comb begin
    case (rd_t.field)
      FLD_ADDR_HI: host_rdata = hi_q[rd_t.half];
      FLD_ADDR_LO: host_rdata = lo_q[rd_t.half];
      FLD_LEN:     host_rdata = 32'(len_q[rd_t.half]);
      FLD_CTRL:    host_rdata = ctrl_q[rd_t.half];
      default:     host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pptx_checker.sv
module pptx_checker (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_start,
  input logic              tx_half,
  input logic              tx_irq,
  input logic              gie,
  input logic              ien,
  input logic [1:0]        busy,
  input logic [1:0]        prog,
  input logic [1:0]        clr,
  input logic [1:0]        ctrl_wr_busy,
  input logic [1:0][31:0]  ctrl,
  input logic [47:0]       station,
  input logic              prog_load,
  input logic              sending,
  input logic              tx_done
);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  assert_start_queued_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (busy[tx_half] && !prog[tx_half]));

  assert_busy_clear0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[0]) |-> $past(clr[0]));

  assert_busy_clear1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[1]) |-> $past(clr[1]));

  assert_station_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(station) |-> $past(prog_load));

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(gie && ien && (|clr)));

  assert_locked_ctrl0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_busy[0] && !clr[0]) |=> $stable(ctrl[0]));

  assert_locked_ctrl1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_busy[1] && !clr[1]) |=> $stable(ctrl[1]));

  assert_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !sending && !prog_load) |=> !tx_irq);
endmodule

bind pingpong_tx_seq pptx_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_start     (tx_start),
  .tx_half      (tx_half),
  .tx_irq       (tx_irq),
  .gie          (gie),
  .ien          (irq_en),
  .busy         (busy_v),
  .prog         (prog_v),
  .clr          (clr_v),
  .ctrl_wr_busy (ctrl_wr_busy_v),
  .ctrl         (ctrl_q),
  .station      (station_addr),
  .prog_load    (prog_load),
  .sending      (sending),
  .tx_done      (tx_done)
);

// File: tb/pingpong_tx_seq_tb.sv
`timescale 1ns/1ps
module pingpong_tx_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [11:0] host_raddr = '0;
  logic [31:0] host_rdata;
  logic        gie = 1'b0;
  logic        tx_start, tx_half, tx_irq;
  logic [15:0] tx_len;
  logic        tx_done = 1'b0;
  logic [47:0] station_addr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pingpong_tx_seq u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .gie(gie), .tx_start(tx_start), .tx_half(tx_half), .tx_len(tx_len),
    .tx_done(tx_done), .station_addr(station_addr), .tx_irq(tx_irq)
  );

  function automatic logic [11:0] ctrl_ofs(input bit h);
    return h ? 12'hFFC : 12'h7FC;
  endfunction
  function automatic logic [11:0] len_ofs(input bit h);
    return h ? 12'hFF4 : 12'h7F4;
  endfunction
  function automatic logic [47:0] exp_station(input logic [31:0] w0, input logic [31:0] w1);
    logic [47:0] s;
    s[47:16] = w0;
    s[15:0]  = w1 & 32'h0000_FFFF;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    host_raddr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic expect_start(input bit h, input logic [15:0] len, input string req);
    bit seen = 1'b0;
    logic [31:0] c;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tx_start) begin seen = 1'b1; break; end
    end
    chk(seen, req, 64'(seen), 64'd1);
    chk(tx_half == h && tx_len == len, req, {tx_half, tx_len}, {h, len});
    rd(ctrl_ofs(h), c);
    chk(c[31] == 1'b1, "R3", 64'(c[31]), 64'd1);
    @(negedge clk);
    chk(!tx_start, "R2", 64'(tx_start), 64'd0);
  endtask

  task automatic finish_frame(input bit h, input int dly, input bit exp_irq, input string req);
    logic [31:0] c;
    repeat (dly) @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk(tx_irq == exp_irq, req, 64'(tx_irq), 64'(exp_irq));
    rd(ctrl_ofs(h), c);
    chk(c[31] == 1'b0, "R3", 64'(c[31]), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(station_addr == 48'h0000_5E00_FACE, "R1", station_addr, 48'h0000_5E00_FACE);
    chk(!tx_start && !tx_irq, "R1", {tx_start, tx_irq}, 0);
    rd(12'h7FC, d); chk(d == 0, "R1", d, 0);
    rd(12'hFF4, d); chk(d == 0, "R1", d, 0);

    // R2/R3/R6/R7 ping frame with interrupt
    gie = 1'b1;
    wr(12'h7F4, 32'd60);
    wr(12'h7FC, 32'h8000_0008);
    expect_start(1'b0, 16'd60, "R2");
    wr(12'h7FC, 32'h0000_0000);
    rd(12'h7FC, d); chk(d == 32'h8000_0008, "R7", d, 32'h8000_0008);
    finish_frame(1'b0, 3, 1'b1, "R6");

    // R9 stray done while idle
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    chk(!tx_irq && !tx_start, "R9", {tx_irq, tx_start}, 0);
    repeat (3) @(negedge clk);
    chk(!tx_start, "R9", 64'(tx_start), 0);
    rd(12'h7FC, d); chk(d == 32'h0000_0008, "R9", d, 32'h8);

    // R6 gie low suppresses, pong alone
    gie = 1'b0;
    wr(12'hFF4, 32'd1500);
    wr(12'hFFC, 32'h8000_0000);
    expect_start(1'b1, 16'd1500, "R2");
    finish_frame(1'b1, 2, 1'b0, "R6");

    // R5/R8 hand-over to pong written during ping
    gie = 1'b1;
    wr(12'h7F4, 32'd100);
    wr(12'h7FC, 32'h8000_0008);
    expect_start(1'b0, 16'd100, "R2");
    wr(12'hFF4, 32'd200);
    wr(12'hFFC, 32'h8000_0000);
    wr(12'hFFC, 32'h0000_0000);
    rd(12'hFFC, d); chk(d == 32'h8000_0000, "R7", d, 32'h8000_0000);
    finish_frame(1'b0, 1, 1'b1, "R6");
    expect_start(1'b1, 16'd200, "R5");
    finish_frame(1'b1, 0, 1'b1, "R8");

    // R6 ien low
    wr(12'h7FC, 32'h8000_0000);
    expect_start(1'b0, 16'd100, "R2");
    finish_frame(1'b0, 2, 1'b0, "R6");
    repeat (3) @(negedge clk);
    chk(!tx_start, "R5", 64'(tx_start), 0);

    // R4 address load from ping
    wr(12'h000, 32'h0A1B_2C3D);
    wr(12'h004, 32'h0000_4E5F);
    wr(12'h7FC, 32'hC000_0008);
    @(negedge clk);
    chk(station_addr == exp_station(32'h0A1B_2C3D, 32'h0000_4E5F), "R4",
        station_addr, exp_station(32'h0A1B_2C3D, 32'h0000_4E5F));
    chk(tx_irq == 1'b1, "R6", 64'(tx_irq), 1);
    chk(!tx_start, "R4", 64'(tx_start), 0);
    rd(12'h7FC, d); chk(d == 32'h0000_0008, "R4", d, 32'h8);

    // R4 address load from pong
    wr(12'h800, 32'h1122_3344);
    wr(12'h804, 32'hAAAA_5566);
    wr(12'hFFC, 32'hC000_0000);
    @(negedge clk);
    chk(station_addr == exp_station(32'h1122_3344, 32'hAAAA_5566), "R4",
        station_addr, exp_station(32'h1122_3344, 32'hAAAA_5566));
    chk(tx_irq == 1'b1, "R6", 64'(tx_irq), 1);
    rd(12'hFFC, d); chk(d == 0, "R4", d, 0);
    repeat (3) @(negedge clk);
    chk(!tx_start, "R4", 64'(tx_start), 0);

    // constrained random: first half, optional second half queued behind it
    for (int it = 0; it < 24; it++) begin
      bit first = 1'(($urandom % 2));
      bit both  = 1'(($urandom % 2));
      bit ien   = 1'(($urandom % 2));
      logic [15:0] l0 = 16'($urandom);
      logic [15:0] l1 = 16'($urandom);
      gie = 1'(($urandom % 2));
      wr(12'h7FC, {28'd0, ien, 3'd0});
      wr(len_ofs(first), 32'(l0));
      wr(ctrl_ofs(first), {1'b1, 27'd0, (first ? 1'b0 : ien), 3'd0});
      expect_start(first, l0, "R2");
      if (both) begin
        wr(len_ofs(!first), 32'(l1));
        wr(ctrl_ofs(!first), {1'b1, 27'd0, (first ? ien : 1'b0), 3'd0});
      end
      finish_frame(first, int'($urandom % 6), gie & ien, "R6");
      if (both) begin
        expect_start(!first, l1, "R5");
        finish_frame(!first, int'($urandom % 6), gie & ien, "R6");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule